// File: doc/BRIEF.md
# Target-Cycle Channel Timing Model

This block models a one-way, point-to-point link between two emulated units whose clocks are counted in target cycles rather than host cycles. In each of its target cycles the sending unit hands the channel exactly one fragment. A fragment is either a data word or an idle marker. The idle marker carries no payload but still stands for one elapsed target cycle. The receiving unit takes exactly one fragment per target cycle of its own. Each side advances its target cycle only when its host-side valid/ready handshake completes. The channel therefore both carries data and keeps the two units' notions of simulated time aligned.

A fragment accepted in sender target cycle t is presented to the receiver in receiver target cycle t+LAT, never earlier. Fragments arrive in the order they were sent, with tag and payload unchanged. At reset the link is empty, so for the first LAT receiver cycles there is nothing real to deliver. The channel then presents synthesized idle fragments for those cycles. Storage holds at most DEPTH fragments. When the store is full the sender is stalled, and its target clock stays where it is until space frees.

Fragment width, latency and depth are compile-time parameters. The parameter set is rejected at elaboration unless LAT is at least 1 and DEPTH is at least LAT.

Top module: `tcc_channel`

## Requirements
- R1: After reset both target-cycle counters read 0, no fragment is stored, and `snd_ready` is 1.
- R2: `snd_cycle` increases by exactly one on each host edge where `snd_valid` and `snd_ready` are both 1, and holds otherwise.
- R3: `rcv_cycle` increases by exactly one on each host edge where `rcv_valid` and `rcv_ready` are both 1, and holds otherwise.
- R4: While `rcv_cycle` is below LAT after reset, the output is a filler fragment: `rcv_valid`=1, `rcv_is_data`=0, `rcv_payload`=0.
- R5: The fragment accepted in sender cycle t is the one presented in receiver cycle t+LAT. Fragments keep FIFO order and arrive with unchanged payload.
- R6: The tag bit marks the fragment type, 1 for data and 0 for idle. Idle fragments are stored, delayed and consumed exactly like data fragments, and the tag is carried through unchanged.
- R7: Once `rcv_cycle` is at least LAT, `rcv_valid` is 0 whenever the fragment for the current receiver cycle has not yet been accepted. A fragment accepted on one edge is visible no earlier than the next host cycle.
- R8: With DEPTH fragments stored and no stored fragment leaving in the same host cycle, `snd_ready` is 0. A fragment offered in that cycle is dropped and `snd_cycle` does not move.
- R9: Elaboration rejects LAT<1 or DEPTH<LAT. With legal parameters, a sender offering every cycle to a receiver accepting every cycle always sees `snd_ready`=1.
- R10: `rcv_ready` asserted while `rcv_valid` is 0 changes nothing: `rcv_cycle` and the stored fragments stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snd_valid | input | 1 | Sender offers a fragment for its current target cycle |
| snd_ready | output | 1 | Channel can take the offered fragment |
| snd_is_data | input | 1 | Tag of offered fragment: 1 data, 0 idle |
| snd_payload | input | W | Payload of offered fragment |
| snd_cycle | output | CYC_W | Sender target-cycle counter |
| rcv_valid | output | 1 | A fragment is presented for the receiver's current target cycle |
| rcv_ready | input | 1 | Receiver consumes the presented fragment |
| rcv_is_data | output | 1 | Tag of presented fragment |
| rcv_payload | output | W | Payload of presented fragment |
| rcv_cycle | output | CYC_W | Receiver target-cycle counter |

## Verification
The bench sets DEPTH equal to LAT, which is the tightest legal setting. A channel that does not let a departing fragment free its slot in the same cycle would then stall a sender that never pauses. The bench drives the store full while the receiver is still inside its filler window. A design that popped stored fragments during the filler cycles would deliver data LAT cycles too early. A design that ignored the full state would overwrite the oldest fragment. The bench also lets the sender fall behind after the filler window, and issues a reset partway through traffic. A wrong design would either raise `rcv_valid` on an empty store, or keep stale fragments and counters past the reset.

// File: rtl/tcc_pkg.sv
// Package: shared types for the target-cycle channel.
// Assumes: nothing; pure type definitions.
package tcc_pkg;
    // Fragment type carried next to every payload.
    typedef enum logic {
        FRAG_IDLE = 1'b0,
        FRAG_DATA = 1'b1
    } frag_kind_e;
endpackage

// File: rtl/tcc_cycle_ctr.sv
// Module: target-cycle counter for one end of the channel.
// Counts completed target cycles; wraps modulo 2**CYC_W.
// Assumes: step is high for at most one host cycle per target cycle.
module tcc_cycle_ctr #(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CYC_W-1:0] cycle
);
    // Advance the target cycle on each completed handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)    cycle <= '0;
        else if (step) cycle <= cycle + 1'b1;
    end

    // R2 R3
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cycle == $past(cycle) + 1'b1);
    // R10
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cycle));
endmodule

// File: rtl/tcc_frag_store.sv
// Module: circular store of in-flight fragments with their release cycle.
// Push writes the tail, pop drops the head; both may occur in one cycle.
// Assumes: the caller never pushes when full without popping in the same
// cycle, and never pops when empty.
module tcc_frag_store
    import tcc_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  frag_kind_e       in_kind,
    input  logic [W-1:0]     in_payload,
    input  logic [CYC_W-1:0] in_release,
    output frag_kind_e       head_kind,
    output logic [W-1:0]     head_payload,
    output logic [CYC_W-1:0] head_release,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    frag_kind_e       kind_mem [DEPTH];
    logic [W-1:0]     pay_mem  [DEPTH];
    logic [CYC_W-1:0] rel_mem  [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    // Write the incoming fragment at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            kind_mem[wr_ptr] <= in_kind;
            pay_mem[wr_ptr]  <= in_payload;
            rel_mem[wr_ptr]  <= in_release;
        end
    end

    // Move pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Present the head entry.
    always_comb begin
        head_kind    = kind_mem[rd_ptr];
        head_payload = pay_mem[rd_ptr];
        head_release = rel_mem[rd_ptr];
        empty        = (count == '0);
        full         = (count == CNT_W'(DEPTH));
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |-> pop);
    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/tcc_release_gate.sv
// Module: decides what the receiver sees in its current target cycle.
// For the first LAT receiver cycles it presents filler idle fragments;
// afterwards it presents the stored head once its release cycle is due.
// Assumes: rx_cycle advances exactly when take is high.
module tcc_release_gate
    import tcc_pkg::*;
#(
    parameter int W     = 8,
    parameter int LAT   = 3,
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] rx_cycle,
    input  logic             empty,
    input  frag_kind_e       head_kind,
    input  logic [W-1:0]     head_payload,
    input  logic [CYC_W-1:0] head_release,
    input  logic             rcv_ready,
    output logic             rcv_valid,
    output logic             rcv_is_data,
    output logic [W-1:0]     rcv_payload,
    output logic             take,
    output logic             pop,
    output logic             in_fill
);
    localparam int FILL_W = $clog2(LAT + 1);

    logic [FILL_W-1:0] fill_left;
    logic              due;

    // Count down the filler cycles left after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        fill_left <= FILL_W'(LAT);
        else if (take && fill_left != '0)  fill_left <= fill_left - 1'b1;
    end

    // Select filler or the due head fragment.
    always_comb begin
        in_fill     = (fill_left != '0);
        due         = !empty && (head_release == rx_cycle);
        rcv_valid   = in_fill || due;
        rcv_is_data = !in_fill && due && (head_kind == FRAG_DATA);
        rcv_payload = (!in_fill && due) ? head_payload : '0;
        take        = rcv_valid && rcv_ready;
        pop         = take && !in_fill;
    end

    // R4
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && !rcv_ready) |=> $stable(fill_left));
    // R4
    fill_only_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_fill |=> !in_fill);
endmodule

// File: rtl/tcc_channel.sv
// Module: target-cycle channel timing model (top).
// One fragment per target cycle per side; a fragment sent in sender
// cycle t is delivered in receiver cycle t+LAT; at most DEPTH stored.
// Assumes: LAT >= 1 and DEPTH >= LAT (checked at elaboration).
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int W     = 8,
    parameter int LAT   = 3,
    parameter int DEPTH = 4,
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snd_valid,
    output logic             snd_ready,
    input  logic             snd_is_data,
    input  logic [W-1:0]     snd_payload,
    output logic [CYC_W-1:0] snd_cycle,
    output logic             rcv_valid,
    input  logic             rcv_ready,
    output logic             rcv_is_data,
    output logic [W-1:0]     rcv_payload,
    output logic [CYC_W-1:0] rcv_cycle
);
    // R9: reject parameter sets that could stall a never-pausing sender.
    if (LAT < 1 || DEPTH < LAT) begin : g_bad_params
        $error("tcc_channel: need LAT >= 1 and DEPTH >= LAT");
    end

    frag_kind_e       head_kind;
    logic [W-1:0]     head_payload;
    logic [CYC_W-1:0] head_release;
    logic             empty, full, push, pop, take, in_fill;
    logic [CYC_W-1:0] release_at;
    frag_kind_e       snd_kind;

    // Handshake decode on the sending side.
    always_comb begin
        snd_ready  = !full || pop;
        push       = snd_valid && snd_ready;
        release_at = snd_cycle + CYC_W'(LAT);
        snd_kind   = snd_is_data ? FRAG_DATA : FRAG_IDLE;
    end

    tcc_cycle_ctr #(.CYC_W(CYC_W)) u_tx_ctr (
        .clk(clk), .rst_n(rst_n), .step(push), .cycle(snd_cycle)
    );

    tcc_cycle_ctr #(.CYC_W(CYC_W)) u_rx_ctr (
        .clk(clk), .rst_n(rst_n), .step(take), .cycle(rcv_cycle)
    );

    tcc_frag_store #(.W(W), .DEPTH(DEPTH), .CYC_W(CYC_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .in_kind(snd_kind), .in_payload(snd_payload), .in_release(release_at),
        .head_kind(head_kind), .head_payload(head_payload),
        .head_release(head_release), .empty(empty), .full(full)
    );

    tcc_release_gate #(.W(W), .LAT(LAT), .CYC_W(CYC_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .rx_cycle(rcv_cycle), .empty(empty),
        .head_kind(head_kind), .head_payload(head_payload),
        .head_release(head_release), .rcv_ready(rcv_ready),
        .rcv_valid(rcv_valid), .rcv_is_data(rcv_is_data),
        .rcv_payload(rcv_payload), .take(take), .pop(pop), .in_fill(in_fill)
    );

    // R5: once filler is over, the stored head is always the one due now.
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !in_fill) |-> head_release == rcv_cycle);
    // R7
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !in_fill) |-> !rcv_valid);
    // R4
    filler_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_fill |-> (rcv_valid && !rcv_is_data));
endmodule

// File: tb/tcc_channel_tb.sv
module tcc_channel_tb;
    localparam int W = 8, LAT = 3, DEPTH = 3, CYC_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic snd_valid = 0, snd_is_data = 0, rcv_ready = 0;
    logic [W-1:0] snd_payload = '0;
    logic snd_ready, rcv_valid, rcv_is_data;
    logic [W-1:0] rcv_payload;
    logic [CYC_W-1:0] snd_cycle, rcv_cycle;

    int n_chk = 0, n_bad = 0;
    int tx = 0, rx = 0;
    logic [W:0] q[$];

    always #10 clk = ~clk;

    tcc_channel #(.W(W), .LAT(LAT), .DEPTH(DEPTH), .CYC_W(CYC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_ready(snd_ready),
        .snd_is_data(snd_is_data), .snd_payload(snd_payload), .snd_cycle(snd_cycle),
        .rcv_valid(rcv_valid), .rcv_ready(rcv_ready), .rcv_is_data(rcv_is_data),
        .rcv_payload(rcv_payload), .rcv_cycle(rcv_cycle)
    );

    // Stimulus table: {snd_valid, snd_is_data, rcv_ready, payload[7:0]}
    localparam logic [10:0] STIM [0:23] = '{
        {3'b111, 8'h11}, {3'b111, 8'h22}, {3'b101, 8'h00}, {3'b111, 8'h33},
        {3'b111, 8'h44}, {3'b001, 8'h00}, {3'b001, 8'h00}, {3'b111, 8'h55},
        {3'b110, 8'h66}, {3'b110, 8'h77}, {3'b100, 8'h00}, {3'b111, 8'h88},
        {3'b001, 8'h00}, {3'b001, 8'h00}, {3'b001, 8'h00}, {3'b001, 8'h00},
        {3'b111, 8'h99}, {3'b101, 8'h00}, {3'b111, 8'hAA}, {3'b011, 8'h00},
        {3'b111, 8'hBB}, {3'b111, 8'hCC}, {3'b001, 8'h00}, {3'b001, 8'h00}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One host cycle: drive, compare against the model, then advance the model.
    task automatic step(input logic sv, input logic sd, input logic rr,
                        input logic [W-1:0] pl, input string ready_tag);
        logic exp_rv, exp_sr, pop_now;
        @(negedge clk);
        snd_valid = sv; snd_is_data = sd; rcv_ready = rr; snd_payload = pl;
        #1;
        exp_rv  = (rx < LAT) || (q.size() > 0);
        pop_now = rr && exp_rv && (rx >= LAT);
        exp_sr  = (q.size() < DEPTH) || pop_now;
        chk(ready_tag, "snd_ready", 32'(snd_ready), 32'(exp_sr));
        chk((rx < LAT) ? "R4" : "R7", "rcv_valid", 32'(rcv_valid), 32'(exp_rv));
        if (exp_rv) begin
            chk("R6", "rcv_is_data", 32'(rcv_is_data),
                (rx < LAT) ? 32'd0 : 32'(q[0][W]));
            chk((rx < LAT) ? "R4" : "R5", "rcv_payload", 32'(rcv_payload),
                (rx < LAT) ? 32'd0 : 32'(q[0][W-1:0]));
        end
        chk("R2", "snd_cycle", 32'(snd_cycle), 32'(tx));
        chk(exp_rv ? "R3" : "R10", "rcv_cycle", 32'(rcv_cycle), 32'(rx));
        @(posedge clk);
        if (pop_now) void'(q.pop_front());
        if (rr && exp_rv) rx++;
        if (sv && exp_sr) begin q.push_back({sd, pl}); tx++; end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; snd_valid = 0; rcv_ready = 0;
        @(posedge clk); @(negedge clk); rst_n = 1;
        tx = 0; rx = 0; q.delete();
        #1;
        chk("R1", "snd_cycle", 32'(snd_cycle), 0);
        chk("R1", "rcv_cycle", 32'(rcv_cycle), 0);
        chk("R1", "snd_ready", 32'(snd_ready), 1);
        chk("R4", "rcv_valid filler", 32'(rcv_valid), 1);
        chk("R4", "rcv_is_data filler", 32'(rcv_is_data), 0);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // Table walk: mixed data, idle, stalls and sender-behind cycles.
        for (int i = 0; i < 24; i++)
            step(STIM[i][10], STIM[i][9], STIM[i][8], STIM[i][7:0], "R8");

        // R1: reset in mid-traffic clears store and both counters.
        do_reset();

        // R8: fill the store during filler window with receiver stalled.
        for (int i = 0; i < DEPTH + 2; i++) step(1, 1, 0, 8'(8'hD0 + i), "R8");
        chk("R8", "snd_cycle frozen when full", 32'(snd_cycle), DEPTH);
        // Drain filler; R4: stored data must not leak out early.
        for (int i = 0; i < LAT; i++) step(0, 0, 1, 8'h00, "R8");
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 8'h00, "R8");
        // R10: ready on empty store does nothing.
        step(0, 0, 1, 8'h00, "R8");
        chk("R10", "rcv_cycle held on empty", 32'(rcv_cycle), LAT + DEPTH);
        // R7: a fragment accepted now is not visible in the same cycle.
        step(1, 1, 1, 8'hE1, "R8");
        step(0, 0, 1, 8'h00, "R8");

        // R9: continuous stream with DEPTH == LAT never stalls the sender.
        do_reset();
        for (int i = 0; i < 40; i++) step(1, i[0], 1, 8'(i * 7), "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule